// File: doc/BRIEF.md
# Processor Privilege and Mode Controller

This block keeps track of the execution context of a small 32-bit core. The context has two parts: a privilege level, which is privileged or user, and a mode, which is thread or handler. Handler mode always runs privileged, so the block holds one of three named states:

- `ST_PRIV_THREAD` (code 00)
- `ST_USER_THREAD` (code 01)
- `ST_PRIV_HANDLER` (code 10)

Code 11 is never produced.

The core's exception logic drives three one-cycle strobes:

- **Exception entry** takes the number of the exception being serviced.
- **Exception return** ends the current handler.
- **Drop request** lowers the thread to user level.

Exception entry moves the block to handler mode and latches the number into the 9-bit exception-number field of the status word. The privilege level that the thread had at that moment is saved. Exception return restores that saved thread level and clears the number to 0. A protected-resource access is a request from the core to touch a privileged-only instruction, special register, configuration register or debug component. When the block is at user level, such an access raises a fault pulse, and the exception logic decides what to do with it. At privileged level every access is allowed. The block also produces the select line for the process stack pointer.

The named transitions are:

- `T_ENTER`: any state to `ST_PRIV_HANDLER`.
- `T_NEST`: `ST_PRIV_HANDLER` to itself on a new entry.
- `T_RETURN`: `ST_PRIV_HANDLER` to the saved thread state.
- `T_DROP`: `ST_PRIV_THREAD` to `ST_USER_THREAD`.

Top module: `pmc_priv_mode_ctrl`

## Requirements
- R1: After reset `mode_o` is 00 (`ST_PRIV_THREAD`), `exc_num_o` is 0, `fault_o` is 0 and `psp_sel_o` is 0.
- R2: `mode_o` bit 1 means handler mode and bit 0 means user level. Only the codes 00, 01 and 10 occur.
- R3: An `exc_enter_i` strobe sets `mode_o` to 10 on the next cycle and loads `exc_num_i` into `exc_num_o`. This holds from any state.
- R4: An `exc_return_i` strobe in `ST_PRIV_HANDLER` restores the saved thread level on the next cycle (00 or 01) and clears `exc_num_o` to 0. In thread mode the strobe is ignored and all outputs keep their values.
- R5: A `drop_req_i` strobe moves `ST_PRIV_THREAD` to `ST_USER_THREAD`. In any other state it is ignored.
- R6: `ST_USER_THREAD` is left only through exception entry.
- R7: A `prot_access_i` request made at user level makes `fault_o` high on the next cycle, for one cycle per request. A request made at privileged level never raises `fault_o`.
- R8: `psp_sel_o` is 1 exactly when `mode_o` is 01.
- R9: When strobes arrive in the same cycle, entry wins over return, and return wins over drop.
- R10: A nested entry while in handler mode keeps the thread level saved at the first entry. A later return goes back to that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_enter_i | input | 1 | Exception entry strobe |
| exc_num_i | input | 9 | Number of the exception being entered |
| exc_return_i | input | 1 | Exception return strobe |
| drop_req_i | input | 1 | Request to lower the thread to user level |
| prot_access_i | input | 1 | Request to touch a protected resource |
| mode_o | output | 2 | State code: bit 1 = handler, bit 0 = user |
| exc_num_o | output | 9 | Exception-number field of the status word |
| fault_o | output | 1 | Illegal-access fault pulse |
| psp_sel_o | output | 1 | 1 = process stack pointer, 0 = main stack pointer |

## Verification
The assertions assume that each strobe is a clean single-cycle level sampled at the rising edge. They also assume that `exc_num_i` is meaningful only while `exc_enter_i` is high, and that the inputs carry no X after reset. The bench drives every input at the falling edge and holds it for exactly one cycle. It gives a single step several strobes only in the priority scenarios. In every other step it keeps `exc_num_i` at 0 unless entry is asserted, so the properties see the input contract that they take for granted.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int EXC_W  = 9;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        ST_PRIV_THREAD  = 2'b00,
        ST_USER_THREAD  = 2'b01,
        ST_PRIV_HANDLER = 2'b10
    } ctx_e;
endpackage

// File: rtl/pmc_ctx_fsm.sv
module pmc_ctx_fsm
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic ret_i,
    input  logic drop_i,
    output ctx_e state_o,
    output logic ret_take_o
);
    ctx_e state_q, state_d;
    logic saved_user_q, saved_user_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_PRIV_THREAD;
            saved_user_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            saved_user_q <= saved_user_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        saved_user_d = saved_user_q;
        ret_take_o   = 1'b0;
        unique case (state_q)
            ST_PRIV_THREAD: begin
                if (enter_i) begin
                    state_d      = ST_PRIV_HANDLER;
                    saved_user_d = 1'b0;
                end else if (drop_i) begin
                    state_d = ST_USER_THREAD;
                end
            end
            ST_USER_THREAD: begin
                if (enter_i) begin
                    state_d      = ST_PRIV_HANDLER;
                    saved_user_d = 1'b1;
                end
            end
            ST_PRIV_HANDLER: begin
                if (!enter_i && ret_i) begin
                    ret_take_o = 1'b1;
                    state_d    = saved_user_q ? ST_USER_THREAD : ST_PRIV_THREAD;
                end
            end
            default: state_d = ST_PRIV_THREAD;
        endcase
    end

    assign state_o = state_q;

    // R3
    enter_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> state_q == ST_PRIV_HANDLER);
    // R6
    user_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USER_THREAD && !enter_i) |=> state_q == ST_USER_THREAD);
    // R5
    drop_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRIV_HANDLER && !ret_i) |=> state_q == ST_PRIV_HANDLER);
endmodule

// File: rtl/pmc_excnum_reg.sv
module pmc_excnum_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         clear_i,
    input  logic [W-1:0] num_i,
    output logic [W-1:0] num_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       num_o <= '0;
        else if (load_i)  num_o <= num_i;
        else if (clear_i) num_o <= '0;
    end

    // R3
    num_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> num_o == $past(num_i));
    // R4
    num_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !load_i) |=> num_o == '0);
endmodule

// File: rtl/pmc_access_guard.sv
module pmc_access_guard
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctx_e state_i,
    input  logic access_i,
    output logic fault_o,
    output logic psp_sel_o
);
    logic at_user;
    assign at_user = (state_i == ST_USER_THREAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_o <= 1'b0;
        else        fault_o <= access_i && at_user;
    end

    assign psp_sel_o = at_user;

    // R7
    priv_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_USER_THREAD) |=> !fault_o);
    // R7
    user_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && state_i == ST_USER_THREAD) |=> fault_o);
endmodule

// File: rtl/pmc_priv_mode_ctrl.sv
module pmc_priv_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int EXC_WIDTH = EXC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_enter_i,
    input  logic [EXC_WIDTH-1:0] exc_num_i,
    input  logic                 exc_return_i,
    input  logic                 drop_req_i,
    input  logic                 prot_access_i,
    output logic [1:0]           mode_o,
    output logic [EXC_WIDTH-1:0] exc_num_o,
    output logic                 fault_o,
    output logic                 psp_sel_o
);
    ctx_e state;
    logic ret_take;

    pmc_ctx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_i   (exc_enter_i),
        .ret_i     (exc_return_i),
        .drop_i    (drop_req_i),
        .state_o   (state),
        .ret_take_o(ret_take)
    );

    pmc_excnum_reg #(.W(EXC_WIDTH)) u_num (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (exc_enter_i),
        .clear_i(ret_take),
        .num_i  (exc_num_i),
        .num_o  (exc_num_o)
    );

    pmc_access_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (state),
        .access_i (prot_access_i),
        .fault_o  (fault_o),
        .psp_sel_o(psp_sel_o)
    );

    assign mode_o = state;

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);
    // R8
    stack_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psp_sel_o == (mode_o == 2'b01));
    // R4
    thread_ret_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o[1] && !exc_enter_i) |=> $stable(exc_num_o));
endmodule

// File: tb/pmc_priv_mode_ctrl_tb.sv
module pmc_priv_mode_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter = 1'b0, ret = 1'b0, drop = 1'b0, acc = 1'b0;
    logic [8:0] num = '0;
    logic [1:0] mode;
    logic [8:0] exc;
    logic fault, psp;

    always #2.5 clk = ~clk;

    pmc_priv_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .exc_enter_i(enter), .exc_num_i(num),
        .exc_return_i(ret), .drop_req_i(drop), .prot_access_i(acc),
        .mode_o(mode), .exc_num_o(exc), .fault_o(fault), .psp_sel_o(psp)
    );

    typedef struct {
        logic [1:0] mode;
        logic [8:0] exc;
        logic       fault;
        logic       psp;
        string      tag;
    } exp_t;

    exp_t q[$];
    int compared = 0, mismatched = 0;
    logic [1:0] m_mode = 2'b00;
    logic       m_saved = 1'b0;
    logic [8:0] m_exc = '0;
    logic       m_fault = 1'b0;
    bit done = 0;

    // expected behaviour, from the requirements
    task automatic step(input logic e, input logic [8:0] n, input logic r,
                        input logic d, input logic a, input string tag);
        exp_t it;
        @(negedge clk);
        enter = e; num = n; ret = r; drop = d; acc = a;
        m_fault = a && (m_mode == 2'b01);
        if (e) begin
            if (m_mode != 2'b10) m_saved = m_mode[0];
            m_mode = 2'b10;
            m_exc = n;
        end else if (r && m_mode == 2'b10) begin
            m_mode = {1'b0, m_saved};
            m_exc = '0;
        end else if (d && m_mode == 2'b00) begin
            m_mode = 2'b01;
        end
        it.mode = m_mode; it.exc = m_exc; it.fault = m_fault;
        it.psp = (m_mode == 2'b01); it.tag = tag;
        q.push_back(it);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            compared++;
            if (mode !== it.mode || exc !== it.exc || fault !== it.fault || psp !== it.psp) begin
                mismatched++;
                $display("FAIL %s: got mode=%b exc=%0d fault=%b psp=%b, exp mode=%b exc=%0d fault=%b psp=%b",
                         it.tag, mode, exc, fault, psp, it.mode, it.exc, it.fault, it.psp);
            end
        end
    end

    initial begin
        #20000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #1;
        compared++;
        if (mode !== 2'b00 || exc !== 0 || fault !== 0 || psp !== 0) begin
            mismatched++;
            $display("FAIL R1: got mode=%b exc=%0d fault=%b psp=%b, exp 00/0/0/0", mode, exc, fault, psp);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1 idle");
        step(0, 0, 0, 0, 1, "R7 priv access no fault");
        step(0, 0, 1, 0, 0, "R4 return in thread ignored");
        step(1, 9'd15, 0, 0, 0, "R3 enter from priv thread");
        step(0, 0, 0, 1, 0, "R5 drop in handler ignored");
        step(0, 0, 0, 0, 1, "R7 handler access no fault");
        step(0, 0, 1, 0, 0, "R4 return to priv thread");
        step(0, 0, 0, 1, 0, "R5 drop in priv thread");
        step(0, 0, 0, 1, 0, "R5 drop in user ignored");
        step(0, 0, 1, 0, 0, "R6 return in user ignored");
        step(0, 0, 0, 0, 1, "R7 user access faults");
        step(0, 0, 0, 0, 0, "R7 fault one cycle");
        step(0, 0, 0, 0, 1, "R7 second request");
        step(0, 0, 0, 0, 1, "R7 back to back");
        step(1, 9'd511, 0, 0, 1, "R3 enter from user, max number");
        step(1, 9'd3, 0, 0, 0, "R10 nested entry");
        step(0, 0, 1, 0, 0, "R10 return to saved user");
        step(0, 0, 0, 0, 0, "R8 stays user");
        step(1, 9'd7, 1, 1, 0, "R9 entry beats return and drop");
        step(0, 0, 1, 1, 0, "R9 return beats drop");
        step(0, 0, 0, 0, 1, "R7 user again");
        step(1, 9'd0, 0, 0, 0, "R3 enter with number 0");
        step(0, 0, 1, 0, 0, "R4 return to user");
        step(0, 0, 0, 0, 0, "R2 final");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule